// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Engine

This block runs one DMA channel from descriptors held in memory. Each descriptor is four 32-bit words in a table at a fixed base address: a control word, a source address, a destination address and a link offset. A pulse on `start` selects a table entry. The engine fetches that entry and decodes the control word. It then copies the described number of 32-bit items from the source to the destination, and both addresses advance by four bytes per item.

Items move only when there is a request. A request is either a software pulse or a peripheral line. In single type each request moves one item. In burst type each request moves a burst of 2^k items, or whatever remains if that is fewer. In basic mode the engine stops after one descriptor. In chained mode it then loads the descriptor at table base plus the link offset, and goes on until it loads a descriptor whose mode is inactive. Completion is signalled by a one-cycle `done` pulse.

Memory is reached through a valid/ready master port. The engine raises `m_valid` with `m_addr`, `m_write` and `m_wdata`. It holds all of them unchanged until `m_ready` is seen high at a rising edge, which completes the access. Read data on `m_rdata` is taken in that same cycle. A memory that holds `m_ready` low stalls the engine without loss.

Top module: `dscdma_engine`

## Requirements
- R1: While reset is asserted and after its release, `busy`, `done` and `m_valid` are low.
- R2: On `start` in idle, table entry n (`start_idx`) is fetched by reading words at TABLE_BASE + 16n + 0, +4, +8 and +12. These are, in that order, the control word, the source address, the destination address and the link offset.
- R3: Control word encoding: bits[1:0] mode (00 inactive, 01 basic, 10 chained, 11 treated as inactive), bit[2] type (1 single, 0 burst), bits[6:4] burst exponent k (burst = 2^k items, k = 0..7), bits[31:16] item count minus one.
- R4: An active descriptor copies exactly count items from the source to the destination, with both addresses rising by 4 per item. Nothing outside the destination range is written. One `done` pulse of one cycle marks the end, with `busy` low in that cycle.
- R5: In single type, each request moves exactly one item.
- R6: In burst type, each request moves min(2^k, remaining) items.
- R7: No item moves while no request is present. `sw_req` and `per_req` are each accepted as a request.
- R8: In chained mode, after the last item the engine fetches the descriptor at TABLE_BASE + link and runs it. The chain ends with `done` when a fetched descriptor is inactive. A basic-mode descriptor inside a chain ends the chain after its own transfer.
- R9: A start on an inactive descriptor gives `done` and writes nothing.
- R10: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_addr`, `m_write` and `m_wdata` stay unchanged on the next cycle.
- R11: `start` while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin at table entry `start_idx` (idle only) |
| start_idx | input | IDXW | Table entry to start from |
| sw_req | input | 1 | Software transfer request |
| per_req | input | 1 | Peripheral transfer request |
| m_valid | output | 1 | Memory access valid |
| m_ready | input | 1 | Memory accepts the access this cycle |
| m_write | output | 1 | 1 write, 0 read |
| m_addr | output | AW | Byte address |
| m_wdata | output | DW | Write data |
| m_rdata | input | DW | Read data, valid when the read handshake completes |
| busy | output | 1 | Engine not idle |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default parameters: a 32-bit bus and a 16-entry table at base 0. It attaches a 256-word memory, so table, source and destination regions all fit in one small array. Counts 1 to 9 and burst exponents 0 to 3 are swept in both types, across table entries 0 to 14 and with and without ready stalls. This covers every partial final burst and the case of one request per item. Requests are given one at a time, so the item count moved per request is measured directly. Chains of four and of two descriptors test link following and early termination.

// File: rtl/dscdma_pkg.sv
package dscdma_pkg;
  localparam int CTL_CNT_W  = 16;
  localparam int DESC_WORDS = 4;

  typedef enum logic [1:0] {
    MD_IDLE  = 2'b00,
    MD_BASIC = 2'b01,
    MD_CHAIN = 2'b10,
    MD_RSVD  = 2'b11
  } run_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_WAIT, ST_READ, ST_WRITE
  } eng_state_e;

  typedef struct packed {
    run_mode_e              mode;
    logic                   single;
    logic [2:0]             bexp;
    logic [CTL_CNT_W-1:0]   cnt_m1;
  } ctl_fields_t;
endpackage

// File: rtl/dscdma_ctl_decode.sv
module dscdma_ctl_decode
  import dscdma_pkg::*;
#(
  parameter int UNIT_W = 17
) (
  input  logic [31:0]       ctl_word,
  output ctl_fields_t       fld,
  output logic              active,
  output logic [UNIT_W-1:0] unit
);
  logic unused_ctl_bits;
  assign unused_ctl_bits = ^{ctl_word[15:7], ctl_word[3]};

  always_comb begin
    fld.mode   = run_mode_e'(ctl_word[1:0]);
    fld.single = ctl_word[2];
    fld.bexp   = ctl_word[6:4];
    fld.cnt_m1 = ctl_word[31:16];
    active     = (fld.mode == MD_BASIC) || (fld.mode == MD_CHAIN);
    unit       = fld.single ? UNIT_W'(1) : (UNIT_W'(1) << fld.bexp);
  end
endmodule

// File: rtl/dscdma_datapath.sv
module dscdma_datapath #(
  parameter int AW    = 32,
  parameter int STEP  = 4,
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    ld_src,
  input  logic [AW-1:0]    ld_dst,
  input  logic [CNT_W-1:0] ld_total,
  input  logic             chunk_go,
  input  logic [CNT_W-1:0] unit,
  input  logic             item_done,
  output logic [AW-1:0]    src,
  output logic [AW-1:0]    dst,
  output logic             last_item,
  output logic             last_in_chunk
);
  logic [AW-1:0]    src_q, dst_q;
  logic [CNT_W-1:0] remain_q, burst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q    <= '0;
      dst_q    <= '0;
      remain_q <= '0;
      burst_q  <= '0;
    end else if (load) begin
      src_q    <= ld_src;
      dst_q    <= ld_dst;
      remain_q <= ld_total;
      burst_q  <= '0;
    end else if (chunk_go) begin
      burst_q  <= (unit < remain_q) ? unit : remain_q;
    end else if (item_done) begin
      src_q    <= src_q + AW'(STEP);
      dst_q    <= dst_q + AW'(STEP);
      remain_q <= remain_q - 1'b1;
      burst_q  <= burst_q - 1'b1;
    end
  end

  assign src           = src_q;
  assign dst           = dst_q;
  assign last_item     = (remain_q == CNT_W'(1));
  assign last_in_chunk = (burst_q == CNT_W'(1));

  p_chunk_fits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_q <= remain_q);
  p_item_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    item_done |-> (remain_q != '0) && (burst_q != '0));
endmodule

// File: rtl/dscdma_engine.sv
module dscdma_engine
  import dscdma_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          DW         = 32,
  parameter int          IDXW       = 4,
  parameter logic [31:0] TABLE_BASE = 32'h0000_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [IDXW-1:0] start_idx,
  input  logic            sw_req,
  input  logic            per_req,
  output logic            m_valid,
  input  logic            m_ready,
  output logic            m_write,
  output logic [AW-1:0]   m_addr,
  output logic [DW-1:0]   m_wdata,
  input  logic [DW-1:0]   m_rdata,
  output logic            busy,
  output logic            done
);
  localparam int STEP     = DW / 8;
  localparam int CNT_W    = CTL_CNT_W + 1;
  localparam int ENTRY_SH = $clog2(DESC_WORDS * 4);
  localparam logic [AW-1:0] BASE = AW'(TABLE_BASE);

  eng_state_e   st_q;
  logic [1:0]   widx_q;
  logic [AW-1:0] desc_q;
  logic [31:0]  w_ctl_q;
  logic [AW-1:0] w_src_q, w_dst_q, w_nxt_q;
  logic [DW-1:0] hold_q;
  logic         done_q;

  ctl_fields_t      fld;
  logic             active;
  logic [CNT_W-1:0] unit;
  logic             req, load, chunk_go, item_done, last_item, last_in_chunk;
  logic [AW-1:0]    src, dst;

  dscdma_ctl_decode #(.UNIT_W(CNT_W)) u_dec (
    .ctl_word(w_ctl_q), .fld(fld), .active(active), .unit(unit)
  );

  assign req       = sw_req | per_req;
  assign load      = (st_q == ST_CHECK) && active;
  assign chunk_go  = (st_q == ST_WAIT) && req;
  assign item_done = (st_q == ST_WRITE) && m_ready;

  dscdma_datapath #(.AW(AW), .STEP(STEP), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .load(load), .ld_src(w_src_q), .ld_dst(w_dst_q),
    .ld_total(CNT_W'(fld.cnt_m1) + CNT_W'(1)),
    .chunk_go(chunk_go), .unit(unit), .item_done(item_done),
    .src(src), .dst(dst), .last_item(last_item), .last_in_chunk(last_in_chunk)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      widx_q  <= '0;
      desc_q  <= '0;
      w_ctl_q <= '0;
      w_src_q <= '0;
      w_dst_q <= '0;
      w_nxt_q <= '0;
      hold_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start) begin
          desc_q <= BASE + (AW'(start_idx) << ENTRY_SH);
          widx_q <= '0;
          st_q   <= ST_FETCH;
        end
        ST_FETCH: if (m_ready) begin
          case (widx_q)
            2'd0:    w_ctl_q <= m_rdata[31:0];
            2'd1:    w_src_q <= AW'(m_rdata);
            2'd2:    w_dst_q <= AW'(m_rdata);
            default: w_nxt_q <= AW'(m_rdata);
          endcase
          widx_q <= widx_q + 2'd1;
          if (widx_q == 2'd3) st_q <= ST_CHECK;
        end
        ST_CHECK: begin
          if (active) st_q <= ST_WAIT;
          else begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        ST_WAIT: if (req) st_q <= ST_READ;
        ST_READ: if (m_ready) begin
          hold_q <= m_rdata;
          st_q   <= ST_WRITE;
        end
        ST_WRITE: if (m_ready) begin
          if (last_item) begin
            if (fld.mode == MD_CHAIN) begin
              desc_q <= BASE + w_nxt_q;
              widx_q <= '0;
              st_q   <= ST_FETCH;
            end else begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end
          end else if (last_in_chunk) st_q <= ST_WAIT;
          else st_q <= ST_READ;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    m_valid = (st_q == ST_FETCH) || (st_q == ST_READ) || (st_q == ST_WRITE);
    m_write = (st_q == ST_WRITE);
    m_wdata = hold_q;
    case (st_q)
      ST_FETCH: m_addr = desc_q + AW'({widx_q, 2'b00});
      ST_READ:  m_addr = src;
      ST_WRITE: m_addr = dst;
      default:  m_addr = '0;
    endcase
  end

  assign busy = (st_q != ST_IDLE);
  assign done = done_q;

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> m_valid && $stable(m_addr) && $stable(m_write) && $stable(m_wdata));
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !m_valid);
  p_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !req) |=> !m_valid);
  p_fetch_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FETCH) |-> !m_write);
  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st_q == ST_WAIT && !req) |=> (st_q == ST_WAIT));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !m_valid);
endmodule

// File: tb/test_dscdma_engine.sv
module test_dscdma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  start_idx = '0;
  logic        sw_req = 1'b0;
  logic        per_req = 1'b0;
  logic        m_valid, m_write, busy, done;
  logic        m_ready = 1'b1;
  logic [31:0] m_addr, m_wdata, m_rdata;

  logic [31:0] mem [256];
  int nwr = 0, ndone = 0, cyc = 0;
  int errors = 0, checks = 0;
  bit stall = 1'b0;

  always #5 clk = ~clk;

  dscdma_engine i_dscdma_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .start_idx(start_idx),
    .sw_req(sw_req), .per_req(per_req), .m_valid(m_valid), .m_ready(m_ready),
    .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
    .busy(busy), .done(done)
  );

  assign m_rdata = mem[m_addr[9:2]];

  always @(posedge clk) begin
    if (m_valid && m_ready && m_write) begin
      mem[m_addr[9:2]] <= m_wdata;
      nwr <= nwr + 1;
    end
    if (done) ndone <= ndone + 1;
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    m_ready = stall ? ((cyc % 3) != 0) : 1'b1;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL R4 watchdog: cycles=%0d expected below 150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctl(int mode, int single, int bexp, int cnt);
    return (32'(cnt - 1) << 16) | (32'(bexp) << 4) | (32'(single) << 2) | 32'(mode);
  endfunction

  task automatic put_desc(int idx, logic [31:0] ctl, logic [31:0] sa, logic [31:0] da, logic [31:0] nx);
    mem[idx*4+0] = ctl; mem[idx*4+1] = sa; mem[idx*4+2] = da; mem[idx*4+3] = nx;
  endtask

  task automatic clear_dst();
    for (int i = 128; i < 256; i++) mem[i] = '0;
  endtask

  task automatic kick(int idx);
    @(negedge clk); start = 1'b1; start_idx = 4'(idx);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(int target);
    int t = 0;
    while (ndone < target && t < 3000) begin @(negedge clk); t++; end
  endtask

  function automatic int copy_errs(int sw, int dw, int n);
    int e = 0;
    for (int j = 0; j < n; j++) if (mem[dw+j] !== mem[sw+j]) e++;
    if (mem[dw+n] !== 32'h0) e++;
    return e;
  endfunction

  task automatic run_basic(int entry, int single, int bexp, int cnt, int soff);
    int d0, w0, e;
    put_desc(entry, mk_ctl(1, single, bexp, cnt), 32'h100 + 32'(4*soff), 32'h200, 32'h0);
    clear_dst();
    d0 = ndone; w0 = nwr;
    per_req = 1'b1;
    kick(entry);
    wait_done(d0 + 1);
    per_req = 1'b0;
    repeat (3) @(negedge clk);
    check(ndone - d0 == 1, "R4 done pulses", ndone - d0, 1);
    check(nwr - w0 == cnt, "R4 write count", nwr - w0, cnt);
    e = copy_errs(64 + soff, 128, cnt);
    check(e == 0, "R2/R3 copied data at entry stride", e, 0);
    check(!busy, "R4 idle after done", busy, 0);
  endtask

  task automatic run_req(int entry, int single, int bexp, int cnt);
    int d0, w0, rem, exp, n;
    put_desc(15, mk_ctl(0, 0, 0, 1), 32'h0, 32'h200, 32'h0);
    put_desc(entry, mk_ctl(1, single, bexp, cnt), 32'h120, 32'h200, 32'h0);
    clear_dst();
    d0 = ndone; w0 = nwr;
    kick(entry);
    repeat (30) @(negedge clk);
    check(nwr == w0, "R7 no move without request", nwr - w0, 0);
    kick(15);
    repeat (10) @(negedge clk);
    check(ndone == d0 && busy, "R11 start ignored while busy", ndone - d0, 0);
    rem = cnt; n = 0;
    while (rem > 0) begin
      w0 = nwr;
      if (n % 2 == 0) sw_req = 1'b1; else per_req = 1'b1;
      @(negedge clk); sw_req = 1'b0; per_req = 1'b0;
      repeat (40) @(negedge clk);
      exp = single ? 1 : (((1 << bexp) < rem) ? (1 << bexp) : rem);
      check(nwr - w0 == exp, single ? "R5 items per request" : "R6 items per request", nwr - w0, exp);
      rem -= exp; n++;
    end
    check(ndone - d0 == 1, "R4 done after last request", ndone - d0, 1);
    check(copy_errs(72, 128, cnt) == 0, "R5/R6 data", copy_errs(72, 128, cnt), 0);
  endtask

  initial begin
    int n, d0, w0, e;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 64; i++) mem[64+i] = 32'hA500_0000 + 32'(i) * 32'h0103_0507;
    repeat (3) @(negedge clk);
    check(!busy && !done && !m_valid, "R1 in reset", {busy, done, m_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && !m_valid, "R1 after reset", {busy, done, m_valid}, 0);

    n = 0;
    for (int single = 0; single < 2; single++)
      for (int bexp = 0; bexp < 4; bexp++)
        for (int cnt = 1; cnt <= 9; cnt++) begin
          stall = (n % 2) == 1;
          run_basic(n % 15, single, bexp, cnt, n % 8);
          n++;
        end

    stall = 1'b1;
    for (int single = 0; single < 2; single++)
      for (int bexp = 0; bexp < 4; bexp++)
        for (int k = 0; k < 3; k++)
          run_req(1 + bexp + 4*single, single, bexp, 1 + 4*k);

    clear_dst();
    put_desc(2,  mk_ctl(2, 1, 0, 3), 32'h100, 32'h200, 32'h50);
    put_desc(5,  mk_ctl(2, 0, 1, 4), 32'h140, 32'h280, 32'hA0);
    put_desc(10, mk_ctl(2, 1, 0, 2), 32'h180, 32'h300, 32'hD0);
    put_desc(13, mk_ctl(0, 0, 0, 1), 32'h0,   32'h0,   32'h0);
    d0 = ndone; w0 = nwr;
    per_req = 1'b1; kick(2); wait_done(d0 + 1); per_req = 1'b0;
    repeat (5) @(negedge clk);
    check(ndone - d0 == 1, "R8 chain single done", ndone - d0, 1);
    check(nwr - w0 == 9, "R8 chain writes", nwr - w0, 9);
    e = copy_errs(64, 128, 3) + copy_errs(80, 160, 4) + copy_errs(96, 192, 2);
    check(e == 0, "R8 chain data", e, 0);

    clear_dst();
    put_desc(0, mk_ctl(1, 1, 0, 5), 32'h100, 32'h380, 32'h0);
    put_desc(5, mk_ctl(1, 0, 2, 4), 32'h140, 32'h280, 32'h0);
    d0 = ndone; w0 = nwr;
    per_req = 1'b1; kick(2); wait_done(d0 + 1); per_req = 1'b0;
    repeat (40) @(negedge clk);
    check(ndone - d0 == 1, "R8 basic ends chain done", ndone - d0, 1);
    check(nwr - w0 == 7, "R8 basic ends chain writes", nwr - w0, 7);

    for (int m = 0; m < 4; m += 3) begin
      put_desc(15, mk_ctl(m, 1, 0, 4), 32'h100, 32'h200, 32'h0);
      d0 = ndone; w0 = nwr;
      per_req = 1'b1; kick(15); wait_done(d0 + 1); per_req = 1'b0;
      repeat (5) @(negedge clk);
      check(ndone - d0 == 1, "R9 inactive start done", ndone - d0, 1);
      check(nwr == w0, "R9 inactive start no writes", nwr - w0, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule